// File: doc/BRIEF.md
# Program Check Trap Entry Controller

This block sits at the retire point of an in-order core. When an instruction completes, a one-cycle completion strobe presents its operation class, an SPR-number high-bit flag, an illegal-encoding flag, an explicit trap request, the current instruction address and the live machine state register. In that same clock the block decides whether a program-check interrupt is taken. It then commits every resulting architectural update together, as registered outputs.

A trap may come from a privileged operation issued in problem state, from an undecodable encoding, or from an explicit request. On a trap, the block saves the instruction address and a copy of the machine state that carries a cause flag. It rewrites the live state into a fixed supervisor configuration, redirects fetch to a single program-check vector, and withholds the destination-register write. When no trap is taken, fetch steps to the next sequential word and the instruction is allowed to write back.

Top module: `trap_entry_ctl`

## Requirements
- R1: Operation class codes on `op_class_i` are 0 ordinary, 1 halt, 2 read-state, 3 write-state, 4 write-state-doubleword, 5 interrupt return, 6 SPR read, 7 SPR write. Codes 1 to 5 are always privileged. Codes 6 and 7 are privileged only when `spr_hi_i` is 1.
- R2: A privileged operation that completes while `msr_i` bit 14 (problem state) is 1 takes a trap, and `srr1_d_o` bit 18 is set. The same operation with bit 14 equal to 0 takes no trap.
- R3: A completing instruction with `illegal_i` set takes a trap, and `srr1_d_o` bit 19 is set. A completing instruction with `trap_req_i` set takes a trap, and `srr1_d_o` bit 17 is set.
- R4: The causes are ranked privilege first, then illegal, then explicit request. Exactly one of the bits 19, 18 and 17 is forced to 1 in `srr1_d_o`. The other two keep their values from `msr_i`.
- R5: On a trap, `srr0_d_o` equals the completing address and `srr1_d_o` equals `msr_i` apart from the cause bit. `msr_d_o` equals `msr_i` with bits 58, 34, 33, 32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 5, 4, 2 and 1 cleared and bits 63 and 0 set.
- R6: After a completion that traps, `nia_o` equals VECTOR (0x700 by default). After a completion that does not trap, `nia_o` equals the completing address plus 4, modulo 2^ADDR_W.
- R7: On a trap, `dest_we_o` is 0 and `srr0_we_o`, `srr1_we_o`, `msr_we_o` and `trap_o` are 1 for that one cycle. On a completion without a trap, `dest_we_o` is 1 and the four trap strobes are 0.
- R8: All outputs appear one clock after the completion edge. In a cycle without completion, every strobe is 0 and `nia_o` holds its value.
- R9: Synchronous reset clears all strobes and sets `nia_o` to RESET_PC (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| complete_i | input | 1 | Instruction completion strobe |
| op_class_i | input | 3 | Operation class code |
| spr_hi_i | input | 1 | SPR number high bit for SPR moves |
| illegal_i | input | 1 | Encoding not recognised |
| trap_req_i | input | 1 | Explicit trap request |
| cia_i | input | ADDR_W | Address of completing instruction |
| msr_i | input | 64 | Live machine state |
| nia_o | output | ADDR_W | Next instruction address |
| srr0_we_o | output | 1 | Save-address register write |
| srr0_d_o | output | ADDR_W | Saved address |
| srr1_we_o | output | 1 | Saved-state register write |
| srr1_d_o | output | 64 | Saved state with cause bit |
| msr_we_o | output | 1 | Machine state write |
| msr_d_o | output | 64 | Rewritten machine state |
| trap_o | output | 1 | One-cycle trap-taken pulse |
| dest_we_o | output | 1 | Destination writeback permitted |

## Verification
Random completions mix every operation class with random machine state, random SPR flags and sparse illegal and request flags. The problem-state bit then splits privileged classes into trapping and non-trapping cases, and the SPR flag separates the two SPR move classes from the always-privileged ones. Directed cases combine several causes at once to expose the ranking. They also zero the live state and fill it with ones, so that the cleared and set bits of the rewrite are told apart from bits passed through. Idle cycles and an address near the top of the range check that the outputs hold their values and that the sequential step wraps.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int unsigned MSR_W = 64;

  typedef enum logic [2:0] {
    OPC_PLAIN     = 3'd0,
    OPC_HALT      = 3'd1,
    OPC_RDSTATE   = 3'd2,
    OPC_WRSTATE   = 3'd3,
    OPC_WRSTATE_D = 3'd4,
    OPC_RETURN    = 3'd5,
    OPC_RDSPR     = 3'd6,
    OPC_WRSPR     = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_PRIV     = 2'd1,
    CAUSE_ILLEGAL  = 2'd2,
    CAUSE_EXPLICIT = 2'd3
  } cause_e;

  // machine state bit positions, bit 0 = least significant
  localparam int unsigned ST_WIDE  = 63;
  localparam int unsigned ST_UNDEF = 58;
  localparam int unsigned ST_TXS1  = 34;
  localparam int unsigned ST_TXS0  = 33;
  localparam int unsigned ST_TXA   = 32;
  localparam int unsigned ST_VECU  = 25;
  localparam int unsigned ST_VSXU  = 23;
  localparam int unsigned ST_EXTI  = 15;
  localparam int unsigned ST_USER  = 14;
  localparam int unsigned ST_FPU   = 13;
  localparam int unsigned ST_FEX0  = 11;
  localparam int unsigned ST_STEP  = 10;
  localparam int unsigned ST_BRTR  = 9;
  localparam int unsigned ST_FEX1  = 8;
  localparam int unsigned ST_IXLT  = 5;
  localparam int unsigned ST_DXLT  = 4;
  localparam int unsigned ST_PMON  = 2;
  localparam int unsigned ST_RCOV  = 1;
  localparam int unsigned ST_LITE  = 0;

  // cause flags written only into the saved copy
  localparam int unsigned CF_ILLEGAL  = 19;
  localparam int unsigned CF_PRIV     = 18;
  localparam int unsigned CF_EXPLICIT = 17;

  localparam int unsigned N_CLEAR = 17;

  function automatic logic [MSR_W-1:0] clear_mask();
    int unsigned pos [N_CLEAR] = '{ST_UNDEF, ST_TXS1, ST_TXS0, ST_TXA, ST_VECU,
                                   ST_VSXU, ST_EXTI, ST_USER, ST_FPU, ST_FEX0,
                                   ST_STEP, ST_BRTR, ST_FEX1, ST_IXLT, ST_DXLT,
                                   ST_PMON, ST_RCOV};
    logic [MSR_W-1:0] m = '0;
    for (int i = 0; i < N_CLEAR; i++) m[pos[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [MSR_W-1:0] set_mask();
    logic [MSR_W-1:0] m = '0;
    m[ST_WIDE] = 1'b1;
    m[ST_LITE] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/trap_priv_decode.sv
module trap_priv_decode
  import trap_entry_pkg::*;
(
  input  op_class_e op_class,
  input  logic      spr_hi,
  output logic      is_priv
);
  always_comb begin
    unique case (op_class)
      OPC_HALT, OPC_RDSTATE, OPC_WRSTATE,
      OPC_WRSTATE_D, OPC_RETURN:  is_priv = 1'b1;
      OPC_RDSPR, OPC_WRSPR:       is_priv = spr_hi;
      default:                    is_priv = 1'b0;
    endcase
  end
endmodule

// File: rtl/trap_cause_arb.sv
module trap_cause_arb
  import trap_entry_pkg::*;
(
  input  logic   is_priv,
  input  logic   user_mode,
  input  logic   illegal,
  input  logic   trap_req,
  output cause_e cause,
  output logic   take
);
  logic priv_fault;
  assign priv_fault = is_priv & user_mode;

  always_comb begin
    if (priv_fault)    cause = CAUSE_PRIV;
    else if (illegal)  cause = CAUSE_ILLEGAL;
    else if (trap_req) cause = CAUSE_EXPLICIT;
    else               cause = CAUSE_NONE;
  end

  assign take = (cause != CAUSE_NONE);
endmodule

// File: rtl/trap_state_rewrite.sv
module trap_state_rewrite
  import trap_entry_pkg::*;
(
  input  logic [MSR_W-1:0] msr_cur,
  input  cause_e           cause,
  output logic [MSR_W-1:0] msr_new,
  output logic [MSR_W-1:0] msr_saved
);
  localparam logic [MSR_W-1:0] CLR = clear_mask();
  localparam logic [MSR_W-1:0] SET = set_mask();

  always_comb begin
    msr_new   = (msr_cur & ~CLR) | SET;
    msr_saved = msr_cur;
    unique case (cause)
      CAUSE_PRIV:     msr_saved[CF_PRIV]     = 1'b1;
      CAUSE_ILLEGAL:  msr_saved[CF_ILLEGAL]  = 1'b1;
      CAUSE_EXPLICIT: msr_saved[CF_EXPLICIT] = 1'b1;
      default:        ;
    endcase
  end
endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
  import trap_entry_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [63:0] VECTOR     = 64'h700,
  parameter logic [63:0] RESET_PC   = 64'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              complete_i,
  input  logic [2:0]        op_class_i,
  input  logic              spr_hi_i,
  input  logic              illegal_i,
  input  logic              trap_req_i,
  input  logic [ADDR_W-1:0] cia_i,
  input  logic [63:0]       msr_i,
  output logic [ADDR_W-1:0] nia_o,
  output logic              srr0_we_o,
  output logic [ADDR_W-1:0] srr0_d_o,
  output logic              srr1_we_o,
  output logic [63:0]       srr1_d_o,
  output logic              msr_we_o,
  output logic [63:0]       msr_d_o,
  output logic              trap_o,
  output logic              dest_we_o
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] VEC_A = VECTOR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] RST_A = RESET_PC[ADDR_W-1:0];

  logic             is_priv, take;
  cause_e           cause;
  logic [MSR_W-1:0] msr_new, msr_saved;

  trap_priv_decode u_dec (
    .op_class (op_class_e'(op_class_i)),
    .spr_hi   (spr_hi_i),
    .is_priv  (is_priv)
  );

  trap_cause_arb u_arb (
    .is_priv   (is_priv),
    .user_mode (msr_i[ST_USER]),
    .illegal   (illegal_i),
    .trap_req  (trap_req_i),
    .cause     (cause),
    .take      (take)
  );

  trap_state_rewrite u_rw (
    .msr_cur   (msr_i),
    .cause     (cause),
    .msr_new   (msr_new),
    .msr_saved (msr_saved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nia_o     <= RST_A;
      srr0_we_o <= 1'b0;
      srr0_d_o  <= '0;
      srr1_we_o <= 1'b0;
      srr1_d_o  <= '0;
      msr_we_o  <= 1'b0;
      msr_d_o   <= '0;
      trap_o    <= 1'b0;
      dest_we_o <= 1'b0;
    end else begin
      srr0_we_o <= complete_i & take;
      srr1_we_o <= complete_i & take;
      msr_we_o  <= complete_i & take;
      trap_o    <= complete_i & take;
      dest_we_o <= complete_i & ~take;
      if (complete_i) begin
        nia_o <= take ? VEC_A : cia_i + STEP;
        if (take) begin
          srr0_d_o <= cia_i;
          srr1_d_o <= msr_saved;
          msr_d_o  <= msr_new;
        end
      end
    end
  end

  // R7: a trap commits all three state writes and suppresses writeback
  assert_trap_commit_R7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (srr0_we_o && srr1_we_o && msr_we_o && !dest_we_o));

  // R8: idle cycle produces no strobes and holds the next address
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !complete_i |=> (!trap_o && !dest_we_o && $stable(nia_o)));

  // R6: sequential step after a non-trapping completion
  assert_seq_step_R6: assert property (@(posedge clk) disable iff (rst)
    (complete_i && !take) |=> (nia_o == $past(cia_i) + STEP));

  // R6: redirect to the vector on a trap
  assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (nia_o == VEC_A));

  // R5: supervisor rewrite forces wide mode and clears problem state
  assert_msr_rewrite_R5: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (msr_d_o[ST_WIDE] && msr_d_o[ST_LITE] && !msr_d_o[ST_USER]));

  // R5: saved address is the completing address
  assert_saved_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (complete_i && take) |=> (srr0_d_o == $past(cia_i)));

  // R4: the saved copy carries at least the selected cause flag
  assert_cause_flag_R4: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ($countones({srr1_d_o[CF_ILLEGAL], srr1_d_o[CF_PRIV],
                            srr1_d_o[CF_EXPLICIT]}) >= 1));
endmodule

// File: tb/trap_entry_ctl_bench.sv
module trap_entry_ctl_bench;
  localparam int unsigned AW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          complete_i, spr_hi_i, illegal_i, trap_req_i;
  logic [2:0]    op_class_i;
  logic [AW-1:0] cia_i;
  logic [63:0]   msr_i;
  logic [AW-1:0] nia_o, srr0_d_o;
  logic [63:0]   srr1_d_o, msr_d_o;
  logic          srr0_we_o, srr1_we_o, msr_we_o, trap_o, dest_we_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_nia;

  always #10 clk = ~clk;

  trap_entry_ctl u_trap_entry_ctl (
    .clk(clk), .rst(rst), .complete_i(complete_i), .op_class_i(op_class_i),
    .spr_hi_i(spr_hi_i), .illegal_i(illegal_i), .trap_req_i(trap_req_i),
    .cia_i(cia_i), .msr_i(msr_i), .nia_o(nia_o), .srr0_we_o(srr0_we_o),
    .srr0_d_o(srr0_d_o), .srr1_we_o(srr1_we_o), .srr1_d_o(srr1_d_o),
    .msr_we_o(msr_we_o), .msr_d_o(msr_d_o), .trap_o(trap_o),
    .dest_we_o(dest_we_o)
  );

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit m_priv(logic [2:0] op, logic hi);
    if (op >= 3'd1 && op <= 3'd5) return 1'b1;
    if (op >= 3'd6) return hi;
    return 1'b0;
  endfunction

  // 0 none, 19 illegal, 18 privilege, 17 explicit
  function automatic int m_cause(logic [2:0] op, logic hi, logic ill,
                                 logic req, logic [63:0] msr);
    if (m_priv(op, hi) && msr[14]) return 18;
    if (ill) return 19;
    if (req) return 17;
    return 0;
  endfunction

  function automatic logic [63:0] m_rewrite(logic [63:0] msr);
    logic [63:0] r = msr;
    int clr [17] = '{1, 2, 4, 5, 8, 9, 10, 11, 13, 14, 15, 23, 25, 32, 33, 34, 58};
    foreach (clr[k]) r[clr[k]] = 1'b0;
    r[0] = 1'b1;
    r[63] = 1'b1;
    return r;
  endfunction

  task automatic step(logic cmp, logic [2:0] op, logic hi, logic ill,
                      logic req, logic [AW-1:0] cia, logic [63:0] msr);
    int c;
    logic [63:0] sv;
    complete_i = cmp; op_class_i = op; spr_hi_i = hi;
    illegal_i = ill; trap_req_i = req; cia_i = cia; msr_i = msr;
    c = m_cause(op, hi, ill, req, msr);
    @(posedge clk); #1;
    if (!cmp) begin
      chk("R8 idle trap", trap_o, 0);
      chk("R8 idle writeback", dest_we_o, 0);
      chk("R8 idle nia hold", nia_o, exp_nia);
    end else if (c != 0) begin
      exp_nia = 64'h700;
      sv = msr; sv[c] = 1'b1;
      chk("R7 trap strobes", {trap_o, srr0_we_o, srr1_we_o, msr_we_o, dest_we_o}, 5'b11110);
      chk("R6 vector", nia_o, exp_nia);
      chk("R5 saved addr", srr0_d_o, cia);
      chk(c == 18 ? "R2 R4 saved state" : "R3 R4 saved state", srr1_d_o, sv);
      chk("R5 state rewrite", msr_d_o, m_rewrite(msr));
    end else begin
      exp_nia = cia + 4;
      chk("R7 no-trap strobes", {trap_o, srr0_we_o, srr1_we_o, msr_we_o, dest_we_o}, 5'b00001);
      chk("R6 R1 sequential", nia_o, exp_nia);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    rst = 1'b1;
    complete_i = 0; op_class_i = 0; spr_hi_i = 0; illegal_i = 0;
    trap_req_i = 0; cia_i = '0; msr_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset trap", trap_o, 0);
    chk("R9 reset strobes", {srr0_we_o, srr1_we_o, msr_we_o, dest_we_o}, 0);
    chk("R9 reset nia", nia_o, 0);
    rst = 1'b0;
    exp_nia = '0;

    // directed corner cases
    for (int op = 0; op < 8; op++) begin
      step(1, 3'(op), 0, 0, 0, 64'h1000 + 64'(op * 8), 64'h4000);   // R1 R2 user mode
      step(1, 3'(op), 1, 0, 0, 64'h2000 + 64'(op * 8), 64'h4000);
      step(1, 3'(op), 1, 0, 0, 64'h3000 + 64'(op * 8), 64'h0);      // R2 supervisor
    end
    step(1, 3'd3, 0, 1, 1, 64'h5000, 64'h4000);          // R4 priv beats all
    step(1, 3'd0, 0, 1, 1, 64'h5004, 64'h4000);          // R4 illegal beats request
    step(1, 3'd0, 0, 0, 1, 64'h5008, 64'h0);             // R3 explicit
    step(1, 3'd2, 0, 1, 0, 64'h500c, '1);                // R5 all-ones state
    step(1, 3'd0, 0, 1, 0, 64'h5010, '0);                // R5 all-zero state
    step(1, 3'd0, 0, 0, 0, '1 - 64'd3, 64'h0);           // R6 wrap
    step(0, 3'd1, 1, 1, 1, 64'h9999, 64'h4000);          // R8 idle ignores flags
    step(0, 3'd0, 0, 0, 0, 64'h0, 64'h0);

    // random mix
    for (int n = 0; n < 2000; n++) begin
      step(($urandom % 8) != 0, 3'($urandom), 1'($urandom),
           ($urandom % 6) == 0, ($urandom % 8) == 0,
           {$urandom, $urandom & 32'hffff_fffc}, {$urandom, $urandom});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule